// File: doc/BRIEF.md
# Chained DMA Descriptor Engine

This block copies data from a backplane address space into host physical memory. It takes its work from a linked list of command packets that sit in memory. Software gives the block the address of the first packet and pulses a start input. The block then runs the whole list as one operation, with no processor involvement between packets. For each packet it reads the four packet words, performs the backplane read cycles the packet asks for, and writes every word it reads to its destination in memory. It then follows the link to the next packet.

Each packet chooses its own cycle type. In single-cycle mode every word has its own address phase. In block mode the address phase is issued once for the whole packet. The list ends at a packet whose end flag is set. The block then reports completion on a status output and can raise an interrupt. A bus error on the backplane side stops the chain and sets an error status instead.

All three external ports use a request/acknowledge handshake. The block fetches packet words on one port, reads the backplane on a second, and writes to memory on a third. It works strictly one step at a time, so at most one request is open at any moment.

Top module: `dma_chain_engine`

## Requirements
- R1: A packet is four 32-bit words fetched at packet address +0, +4, +8 and +12, in that order. The words hold, in turn: the source address, the destination address, {modifier[31:26], length in bytes[25:0]}, and the link word, whose bit 0 is the end flag and whose bits [31:2] give the next packet address.
- R2: When the block is idle, a pulse on go_i starts a run at list_addr_i with bits [1:0] ignored. In the cycle after the pulse, busy_o is high and both done_o and error_o are clear.
- R3: If modifier bits [1:0] are not 2'b11 (single-cycle mode), each word is one backplane read with bus_astb_o high. The read carries the packet's modifier on bus_mod_o, and the source address starts at the packet value and rises by 4 per word.
- R4: If modifier bits [1:0] are 2'b11 (block mode), bus_astb_o is high only on the first read of the packet. The source address still rises by 4 per word.
- R5: Each word read is written unchanged to the destination address plus 4 times its index. This write completes before the next backplane read of the run begins.
- R6: A packet moves length/4 words, with length bits [1:0] ignored. A packet that moves zero words makes no backplane read and no memory write, and the run goes on at its link.
- R7: After the last word of a packet whose end flag is set, or after such a packet with zero words, the run ends with done_o set and busy_o cleared. Packets are visited in link order.
- R8: A backplane read answered with bus_err_i ends the run. That word is not written, no further packet is fetched, error_o is set and done_o stays clear.
- R9: irq_o is high exactly while irq_en_i is high and either done_o or error_o is set.
- R10: A go_i pulse while busy_o is high has no effect on the current run or on which packets are fetched.
- R11: Each request (desc_req_o, bus_req_o, wr_req_o) stays high with its address, modifier and data unchanged until it is acknowledged, or for a read until an error answers it.
- R12: After reset, and at any time while busy_o is low, no request is raised. After reset, busy_o, done_o, error_o and irq_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start pulse, honoured only when idle |
| list_addr_i | input | 32 | Address of the first packet |
| irq_en_i | input | 1 | Interrupt enable |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | The last run finished normally |
| error_o | output | 1 | The last run ended on a bus error |
| irq_o | output | 1 | Interrupt request |
| desc_req_o | output | 1 | Packet word read request |
| desc_addr_o | output | 32 | Packet word address |
| desc_ack_i | input | 1 | Packet word read acknowledge |
| desc_rdata_i | input | 32 | Packet word data |
| bus_req_o | output | 1 | Backplane read request |
| bus_addr_o | output | 32 | Backplane source address |
| bus_mod_o | output | 6 | Cycle type modifier |
| bus_astb_o | output | 1 | Address phase for this read |
| bus_ack_i | input | 1 | Backplane read acknowledge |
| bus_err_i | input | 1 | Backplane read error response |
| bus_rdata_i | input | 32 | Backplane read data |
| wr_req_o | output | 1 | Memory write request |
| wr_addr_o | output | 32 | Memory write address |
| wr_data_o | output | 32 | Memory write data |
| wr_ack_i | input | 1 | Memory write acknowledge |

## Verification
The bench builds the block with its default parameters. These are the 2'b11 block-mode code and the 32-bit word package, with its 6-bit modifier and 26-bit length fields. Under this default, modifier codes such as 0x0B and 0x3F select block mode while 0x09 and 0x0D stay single-cycle, so one list can mix both modes. Because the length field is wide but the packets are kept to a few words, multi-packet chains, zero-length skips, unaligned lengths and list addresses, an error in mid-packet, and a restart after an error all fit in a short run. Response latencies depend on the address, so the handshakes see both immediate and delayed acknowledges.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int DW         = 32;
  localparam int MOD_W      = 6;
  localparam int LEN_W      = DW - MOD_W;
  localparam int DESC_WORDS = 4;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int WB         = DW / 8;
  localparam int WB_SH      = $clog2(WB);
  localparam int CNT_W      = LEN_W - WB_SH;

  typedef struct packed {
    logic [DW-1:0]    src;
    logic [DW-1:0]    dst;
    logic [MOD_W-1:0] mod;
    logic [LEN_W-1:0] len;
    logic [DW-1:0]    next;
    logic             last;
  } pkt_t;

  typedef enum logic [1:0] {C_IDLE, C_FETCH, C_XFER} ctl_e;
  typedef enum logic [1:0] {X_IDLE, X_RD, X_WR} xfr_e;
endpackage

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
  import dma_chain_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] base_i,
  output logic          req_o,
  output logic [DW-1:0] addr_o,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  output logic          done_o,
  output pkt_t          pkt_o
);
  logic                 active_q;
  logic [IDX_W-1:0]     idx_q;
  logic [DW-1:0]        base_q;
  logic [DW-1:0]        word_q [DESC_WORDS];
  logic                 unused_link_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
      done_o   <= 1'b0;
      for (int k = 0; k < DESC_WORDS; k++) word_q[k] <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        base_q   <= base_i;
      end else if (active_q && ack_i) begin
        word_q[idx_q] <= rdata_i;
        idx_q         <= idx_q + 1'b1;
        if (idx_q == IDX_W'(DESC_WORDS - 1)) begin
          active_q <= 1'b0;
          done_o   <= 1'b1;
        end
      end
    end
  end

  assign req_o  = active_q;
  assign addr_o = base_q + (DW'(idx_q) << WB_SH);

  always_comb begin
    pkt_o.src  = word_q[0];
    pkt_o.dst  = word_q[1];
    pkt_o.mod  = word_q[2][DW-1 -: MOD_W];
    pkt_o.len  = word_q[2][LEN_W-1:0];
    pkt_o.next = {word_q[3][DW-1:WB_SH], {WB_SH{1'b0}}};
    pkt_o.last = word_q[3][0];
  end

  assign unused_link_bit = ^word_q[3][WB_SH-1:1];
endmodule

// File: rtl/dma_xfer_unit.sv
module dma_xfer_unit
  import dma_chain_pkg::*;
#(
  parameter logic [1:0] BLOCK_CODE = 2'b11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DW-1:0]    src_i,
  input  logic [DW-1:0]    dst_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic [CNT_W-1:0] words_i,
  output logic             bus_req_o,
  output logic [DW-1:0]    bus_addr_o,
  output logic [MOD_W-1:0] bus_mod_o,
  output logic             bus_astb_o,
  input  logic             bus_ack_i,
  input  logic             bus_err_i,
  input  logic [DW-1:0]    bus_rdata_i,
  output logic             wr_req_o,
  output logic [DW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  input  logic             wr_ack_i,
  output logic             done_o,
  output logic             err_o
);
  xfr_e             state_q;
  logic [DW-1:0]    src_q, dst_q, data_q;
  logic [MOD_W-1:0] mod_q;
  logic [CNT_W-1:0] left_q;
  logic             first_q, block_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= X_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      data_q  <= '0;
      mod_q   <= '0;
      left_q  <= '0;
      first_q <= 1'b0;
      block_q <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        X_IDLE: if (start_i) begin
          src_q   <= src_i;
          dst_q   <= dst_i;
          mod_q   <= mod_i;
          left_q  <= words_i;
          first_q <= 1'b1;
          block_q <= (mod_i[1:0] == BLOCK_CODE);
          state_q <= X_RD;
        end
        X_RD: begin
          // an error response wins over a simultaneous acknowledge
          if (bus_err_i) begin
            err_o   <= 1'b1;
            state_q <= X_IDLE;
          end else if (bus_ack_i) begin
            data_q  <= bus_rdata_i;
            state_q <= X_WR;
          end
        end
        X_WR: if (wr_ack_i) begin
          src_q   <= src_q + DW'(WB);
          dst_q   <= dst_q + DW'(WB);
          left_q  <= left_q - 1'b1;
          first_q <= 1'b0;
          if (left_q == CNT_W'(1)) begin
            done_o  <= 1'b1;
            state_q <= X_IDLE;
          end else begin
            state_q <= X_RD;
          end
        end
        default: state_q <= X_IDLE;
      endcase
    end
  end

  assign bus_req_o  = (state_q == X_RD);
  assign bus_addr_o = src_q;
  assign bus_mod_o  = mod_q;
  assign bus_astb_o = bus_req_o && (!block_q || first_q);
  assign wr_req_o   = (state_q == X_WR);
  assign wr_addr_o  = dst_q;
  assign wr_data_o  = data_q;
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_chain_pkg::*;
#(
  parameter logic [1:0] BLOCK_CODE = 2'b11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [DW-1:0]    list_addr_i,
  input  logic             irq_en_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o,
  output logic             irq_o,
  output logic             desc_req_o,
  output logic [DW-1:0]    desc_addr_o,
  input  logic             desc_ack_i,
  input  logic [DW-1:0]    desc_rdata_i,
  output logic             bus_req_o,
  output logic [DW-1:0]    bus_addr_o,
  output logic [MOD_W-1:0] bus_mod_o,
  output logic             bus_astb_o,
  input  logic             bus_ack_i,
  input  logic             bus_err_i,
  input  logic [DW-1:0]    bus_rdata_i,
  output logic             wr_req_o,
  output logic [DW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  input  logic             wr_ack_i
);
  ctl_e             state_q;
  logic             done_q, err_q, last_q;
  logic [DW-1:0]    next_q;
  logic             fetch_start, fetch_done, xfer_start, xfer_done, xfer_err;
  logic [DW-1:0]    fetch_base;
  pkt_t             pkt;
  logic [CNT_W-1:0] words;
  logic             unused_low;

  assign words      = pkt.len[LEN_W-1:WB_SH];
  assign unused_low = ^{list_addr_i[WB_SH-1:0], pkt.len[WB_SH-1:0]};

  dma_desc_fetch u_fetch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (fetch_start),
    .base_i  (fetch_base),
    .req_o   (desc_req_o),
    .addr_o  (desc_addr_o),
    .ack_i   (desc_ack_i),
    .rdata_i (desc_rdata_i),
    .done_o  (fetch_done),
    .pkt_o   (pkt)
  );

  dma_xfer_unit #(.BLOCK_CODE(BLOCK_CODE)) u_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (xfer_start),
    .src_i       (pkt.src),
    .dst_i       (pkt.dst),
    .mod_i       (pkt.mod),
    .words_i     (words),
    .bus_req_o   (bus_req_o),
    .bus_addr_o  (bus_addr_o),
    .bus_mod_o   (bus_mod_o),
    .bus_astb_o  (bus_astb_o),
    .bus_ack_i   (bus_ack_i),
    .bus_err_i   (bus_err_i),
    .bus_rdata_i (bus_rdata_i),
    .wr_req_o    (wr_req_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .wr_ack_i    (wr_ack_i),
    .done_o      (xfer_done),
    .err_o       (xfer_err)
  );

  always_comb begin
    fetch_start = 1'b0;
    xfer_start  = 1'b0;
    fetch_base  = {list_addr_i[DW-1:WB_SH], {WB_SH{1'b0}}};
    unique case (state_q)
      C_IDLE:  fetch_start = go_i;
      C_FETCH: if (fetch_done) begin
        if (words != '0) begin
          xfer_start = 1'b1;
        end else if (!pkt.last) begin
          fetch_start = 1'b1;
          fetch_base  = pkt.next;
        end
      end
      C_XFER: if (xfer_done && !xfer_err && !last_q) begin
        fetch_start = 1'b1;
        fetch_base  = next_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= C_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      last_q  <= 1'b0;
      next_q  <= '0;
    end else begin
      unique case (state_q)
        C_IDLE: if (go_i) begin
          done_q  <= 1'b0;
          err_q   <= 1'b0;
          state_q <= C_FETCH;
        end
        C_FETCH: if (fetch_done) begin
          last_q <= pkt.last;
          next_q <= pkt.next;
          if (words != '0) begin
            state_q <= C_XFER;
          end else if (pkt.last) begin
            done_q  <= 1'b1;
            state_q <= C_IDLE;
          end
        end
        C_XFER: begin
          if (xfer_err) begin
            err_q   <= 1'b1;
            state_q <= C_IDLE;
          end else if (xfer_done) begin
            if (last_q) begin
              done_q  <= 1'b1;
              state_q <= C_IDLE;
            end else begin
              state_q <= C_FETCH;
            end
          end
        end
        default: state_q <= C_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != C_IDLE);
  assign done_o  = done_q;
  assign error_o = err_q;
  assign irq_o   = irq_en_i && (done_q || err_q);
endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        go_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        error_o,
  input logic        irq_o,
  input logic        desc_req_o,
  input logic [31:0] desc_addr_o,
  input logic        desc_ack_i,
  input logic        bus_req_o,
  input logic [31:0] bus_addr_o,
  input logic [5:0]  bus_mod_o,
  input logic        bus_ack_i,
  input logic        bus_err_i,
  input logic        wr_req_o,
  input logic [31:0] wr_addr_o,
  input logic [31:0] wr_data_o,
  input logic        wr_ack_i
);
  a_r11_desc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_req_o && !desc_ack_i |=> desc_req_o && $stable(desc_addr_o));

  a_r11_bus_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i && !bus_err_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_mod_o));

  a_r11_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));

  a_r5_single_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({desc_req_o, bus_req_o, wr_req_o}) <= 1);

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !desc_req_o && !bus_req_o && !wr_req_o);

  a_r7_done_ends_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $fell(busy_o));

  a_r8_status_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));

  a_r8_no_write_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> !wr_req_o && !busy_o);

  a_r2_start_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !done_o && !error_o);

  a_r9_irq_quiet_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !irq_o);

  a_r10_go_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && go_i |=> busy_o || done_o || error_o);
endmodule

bind dma_chain_engine dma_chain_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .go_i        (go_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .error_o     (error_o),
  .irq_o       (irq_o),
  .desc_req_o  (desc_req_o),
  .desc_addr_o (desc_addr_o),
  .desc_ack_i  (desc_ack_i),
  .bus_req_o   (bus_req_o),
  .bus_addr_o  (bus_addr_o),
  .bus_mod_o   (bus_mod_o),
  .bus_ack_i   (bus_ack_i),
  .bus_err_i   (bus_err_i),
  .wr_req_o    (wr_req_o),
  .wr_addr_o   (wr_addr_o),
  .wr_data_o   (wr_data_o),
  .wr_ack_i    (wr_ack_i)
);

// File: tb/dma_chain_engine_tb_top.sv
`timescale 1ns/1ps
module dma_chain_engine_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        go_i = 1'b0;
  logic [31:0] list_addr_i = '0;
  logic        irq_en_i = 1'b1;
  logic        busy_o, done_o, error_o, irq_o;
  logic        desc_req_o;
  logic [31:0] desc_addr_o;
  logic        desc_ack_i = 1'b0;
  logic [31:0] desc_rdata_i = '0;
  logic        bus_req_o;
  logic [31:0] bus_addr_o;
  logic [5:0]  bus_mod_o;
  logic        bus_astb_o;
  logic        bus_ack_i = 1'b0;
  logic        bus_err_i = 1'b0;
  logic [31:0] bus_rdata_i = '0;
  logic        wr_req_o;
  logic [31:0] wr_addr_o, wr_data_o;
  logic        wr_ack_i = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dma_chain_engine dut_i (.*);

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    logic [5:0]  mod;
    logic        astb;
    string       tag;
  } ex_t;

  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] mem [logic [31:0]];
  ex_t         q_desc[$];
  ex_t         q_bus[$];
  ex_t         q_wr[$];
  bit          err_en = 1'b0;
  logic [31:0] err_addr = '0;
  int          dcnt = 0, bcnt = 0, wcnt = 0;
  logic        pv_dreq = 0, pv_dack = 0, pv_breq = 0, pv_bdone = 0, pv_wreq = 0, pv_wack = 0;
  logic [31:0] pv_daddr = '0, pv_baddr = '0, pv_waddr = '0, pv_wdata = '0;

  function automatic logic [31:0] bp_data(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h3C5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference: writes the packet into memory and queues the traffic it must cause
  task automatic add_pkt(input logic [31:0] at, input logic [31:0] src, input logic [31:0] dst,
                         input logic [5:0] mod, input logic [25:0] len,
                         input logic [31:0] nxt, input bit last, input int err_at);
    ex_t e;
    int  words;
    bit  blk;
    mem[at]      = src;
    mem[at + 4]  = dst;
    mem[at + 8]  = {mod, len};
    mem[at + 12] = nxt | {31'd0, last};
    for (int k = 0; k < 4; k++) begin
      e = '{addr: at + 32'(4 * k), data: 0, mod: 0, astb: 0, tag: "R1"};
      q_desc.push_back(e);
    end
    words = int'(len >> 2);
    blk   = (mod[1:0] == 2'b11);
    for (int i = 0; i < words; i++) begin
      e = '{addr: src + 32'(4 * i), data: 0, mod: mod,
            astb: blk ? (i == 0) : 1'b1, tag: blk ? "R4" : "R3"};
      q_bus.push_back(e);
      if (i == err_at) break;
      e = '{addr: dst + 32'(4 * i), data: bp_data(src + 32'(4 * i)), mod: 0, astb: 0, tag: "R5"};
      q_wr.push_back(e);
    end
  endtask

  // per-clock comparison and responders
  always @(negedge clk_i) begin
    ex_t e;
    if (rst_ni) begin
      if (pv_dreq && !pv_dack)
        chk(desc_req_o && desc_addr_o == pv_daddr, "R11", "desc request hold", desc_addr_o, pv_daddr);
      if (pv_breq && !pv_bdone)
        chk(bus_req_o && bus_addr_o == pv_baddr, "R11", "bus request hold", bus_addr_o, pv_baddr);
      if (pv_wreq && !pv_wack)
        chk(wr_req_o && wr_addr_o == pv_waddr && wr_data_o == pv_wdata, "R11", "write request hold",
            wr_data_o, pv_wdata);
      if (!busy_o)
        chk(!(desc_req_o || bus_req_o || wr_req_o), "R12", "request while idle",
            {29'd0, desc_req_o, bus_req_o, wr_req_o}, 32'd0);
    end

    if (desc_ack_i) desc_ack_i = 1'b0;
    else if (desc_req_o) begin
      if (dcnt >= int'((desc_addr_o >> 2) % 3)) begin
        dcnt = 0;
        if (q_desc.size() == 0) chk(0, "R10", "unexpected packet fetch", desc_addr_o, 0);
        else begin
          e = q_desc.pop_front();
          chk(desc_addr_o == e.addr, e.tag, "packet word address", desc_addr_o, e.addr);
        end
        desc_rdata_i = mem.exists(desc_addr_o) ? mem[desc_addr_o] : 32'h0;
        desc_ack_i   = 1'b1;
      end else dcnt++;
    end

    if (bus_ack_i || bus_err_i) begin
      bus_ack_i = 1'b0;
      bus_err_i = 1'b0;
    end else if (bus_req_o) begin
      if (bcnt >= int'((bus_addr_o >> 3) % 2)) begin
        bcnt = 0;
        if (q_bus.size() == 0) chk(0, "R6", "unexpected backplane read", bus_addr_o, 0);
        else begin
          e = q_bus.pop_front();
          chk(bus_addr_o == e.addr, e.tag, "read address", bus_addr_o, e.addr);
          chk(bus_mod_o == e.mod, e.tag, "read modifier", {26'd0, bus_mod_o}, {26'd0, e.mod});
          chk(bus_astb_o == e.astb, e.tag, "address strobe", {31'd0, bus_astb_o}, {31'd0, e.astb});
        end
        if (err_en && bus_addr_o == err_addr) bus_err_i = 1'b1;
        else begin
          bus_rdata_i = bp_data(bus_addr_o);
          bus_ack_i   = 1'b1;
        end
      end else bcnt++;
    end

    if (wr_ack_i) wr_ack_i = 1'b0;
    else if (wr_req_o) begin
      if (wcnt >= int'((wr_addr_o >> 2) % 2)) begin
        wcnt = 0;
        if (q_wr.size() == 0) chk(0, "R8", "unexpected memory write", wr_addr_o, 0);
        else begin
          e = q_wr.pop_front();
          chk(wr_addr_o == e.addr, e.tag, "write address", wr_addr_o, e.addr);
          chk(wr_data_o == e.data, e.tag, "write data", wr_data_o, e.data);
        end
        wr_ack_i = 1'b1;
      end else wcnt++;
    end

    pv_dreq = desc_req_o; pv_dack = desc_ack_i; pv_daddr = desc_addr_o;
    pv_breq = bus_req_o;  pv_bdone = bus_ack_i || bus_err_i; pv_baddr = bus_addr_o;
    pv_wreq = wr_req_o;   pv_wack = wr_ack_i; pv_waddr = wr_addr_o; pv_wdata = wr_data_o;
  end

  task automatic run_chain(input logic [31:0] la, input bit en, input bit exp_done,
                           input bit exp_err, input bit go_mid);
    irq_en_i = en;
    @(negedge clk_i);
    list_addr_i = la;
    go_i = 1'b1;
    @(negedge clk_i);
    go_i = 1'b0;
    chk(busy_o == 1'b1, "R2", "busy after go", {31'd0, busy_o}, 32'd1);
    chk(!done_o && !error_o, "R2", "status cleared by go", {30'd0, done_o, error_o}, 32'd0);
    if (go_mid) begin
      repeat (7) @(negedge clk_i);
      list_addr_i = 32'h0000_7000;
      go_i = 1'b1;
      @(negedge clk_i);
      go_i = 1'b0;
    end
    while (busy_o) @(negedge clk_i);
    chk(done_o == exp_done, "R7", "done status", {31'd0, done_o}, {31'd0, exp_done});
    chk(error_o == exp_err, "R8", "error status", {31'd0, error_o}, {31'd0, exp_err});
    chk(irq_o == (en && (exp_done || exp_err)), "R9", "interrupt", {31'd0, irq_o},
        {31'd0, en && (exp_done || exp_err)});
    chk(q_desc.size() == 0, "R7", "packets left unfetched", q_desc.size(), 0);
    chk(q_bus.size() == 0, "R6", "reads left undone", q_bus.size(), 0);
    chk(q_wr.size() == 0, "R5", "writes left undone", q_wr.size(), 0);
    repeat (3) @(negedge clk_i);
    chk(!busy_o, "R10", "no restart from ignored go", {31'd0, busy_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !error_o && !irq_o, "R12", "reset status",
        {28'd0, busy_o, done_o, error_o, irq_o}, 32'd0);
    chk(!desc_req_o && !bus_req_o && !wr_req_o, "R12", "reset requests",
        {29'd0, desc_req_o, bus_req_o, wr_req_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // single-cycle packet, unaligned list address
    add_pkt(32'h100, 32'h4000_0010, 32'h0008_0000, 6'h09, 26'd12, 32'h0, 1'b1, -1);
    run_chain(32'h102, 1'b1, 1'b1, 1'b0, 1'b0);

    // block packet, skipped zero-length packet, single packet with unaligned length; go while busy
    add_pkt(32'h200, 32'h4100_0000, 32'h0009_0000, 6'h0B, 26'd16, 32'h240, 1'b0, -1);
    add_pkt(32'h240, 32'h4A00_0000, 32'h000F_0000, 6'h09, 26'd0, 32'h280, 1'b0, -1);
    add_pkt(32'h280, 32'h4200_0100, 32'h000A_0000, 6'h0D, 26'd10, 32'h0, 1'b1, -1);
    run_chain(32'h200, 1'b0, 1'b1, 1'b0, 1'b1);

    // bus error in the third word of the second packet
    add_pkt(32'h300, 32'h4300_0000, 32'h000B_0000, 6'h3F, 26'd8, 32'h340, 1'b0, -1);
    add_pkt(32'h340, 32'h4400_0000, 32'h000C_0000, 6'h09, 26'd16, 32'h380, 1'b0, 2);
    err_en   = 1'b1;
    err_addr = 32'h4400_0008;
    run_chain(32'h300, 1'b1, 1'b0, 1'b1, 1'b0);
    err_en = 1'b0;

    // restart after an error clears it
    add_pkt(32'h100, 32'h4000_0010, 32'h0008_0000, 6'h09, 26'd12, 32'h0, 1'b1, -1);
    run_chain(32'h100, 1'b1, 1'b1, 1'b0, 1'b0);

    // final packet moves no words
    add_pkt(32'h400, 32'h4500_0000, 32'h000D_0000, 6'h0B, 26'd3, 32'h0, 1'b1, -1);
    run_chain(32'h400, 1'b1, 1'b1, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule